// File: doc/BRIEF.md
# Three-share masked lightweight block cipher core

This core encrypts one 64-bit block under an 80-bit key with the 31-round substitution-permutation cipher that uses a 4-bit S-box, a 64-bit bit permutation and an 80-bit rotating key schedule. The state is held as three Boolean shares whose XOR is the true value. The key is never split into shares. A single shared S-box handles one nibble of all three shares per cycle. It has two register stages: the first applies a quadratic decomposition and is re-masked from an external random input, and the second applies a second quadratic decomposition. The bit permutation acts on all three shares at once in a single cycle.

The user shifts the three plaintext shares in, one nibble per cycle and most significant nibble first. The key is shifted in the same way over 20 cycles, and both loads may overlap. The user then pulses `start`. Each round takes 17 cycles: 16 nibbles pass through the S-box, and the last write-back is merged with the permutation and the key update. After 527 cycles `done` rises. The three result shares are then on the outputs, and the final round-key addition is folded into share 1. `done` stays high and the outputs hold until the next load or start.

Top module: `present3_core`

## Requirements
- R1: After reset `done` is 0 and the XOR of the three result shares is 0.
- R2: While idle, `pt_load` shifts `pt_nib1..3` into the low end of the three state shares and `key_load` shifts `key_nib` into the low end of the key. After 16 and 20 such cycles the first nibble sits in the most significant position. The encrypted block is the XOR of the three loaded shares.
- R3: When `done` is high, `ct1 ^ ct2 ^ ct3` equals the 31-round encryption of the loaded block under the loaded key.
- R4: `done` rises exactly 527 clock edges after the edge that samples `start` high while idle, and it is low in between.
- R5: With shares 2 and 3 loaded as zero and `mask_in` held at zero, the result is still correct.
- R6: The value of `mask_in` (bits 3:0 re-mask share 1, bits 7:4 re-mask share 2, and their XOR re-masks share 3) has no effect on the XOR of the result shares.
- R7: `start`, `pt_load` and `key_load` are ignored while an encryption runs.
- R8: While `done` is high and no load or start is given, the three result shares stay constant.
- R9: An all-zero block under an all-zero key gives 5579C1387B228445. An all-one block under an all-one key gives 3333DCD3213210D2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_load | input | 1 | Shift one nibble into each state share |
| pt_nib1 | input | 4 | Share 1 plaintext nibble |
| pt_nib2 | input | 4 | Share 2 plaintext nibble |
| pt_nib3 | input | 4 | Share 3 plaintext nibble |
| key_load | input | 1 | Shift one nibble into the key |
| key_nib | input | 4 | Key nibble |
| start | input | 1 | Begin encryption when idle |
| mask_in | input | 8 | Fresh random bits for re-masking between S-box stages |
| done | output | 1 | Result valid |
| ct1 | output | 64 | Result share 1 (includes the last key addition) |
| ct2 | output | 64 | Result share 2 |
| ct3 | output | 64 | Result share 3 |

## Verification
The two fixed known-answer vectors, all zeros and all ones, are run with random share splits. They tie both the core and the bench reference to fixed ciphertexts. Random blocks and keys under random share splits and random re-mask bits show that the shared S-box pipeline and the per-share permutation are correct for general data. A run with zero masks and only one non-zero share separates a correct sharing from one that relies on the shares being random. A run where load and start pulses arrive mid-encryption shows that an in-flight run is not disturbed. Every run also measures the exact edge on which `done` rises.

// File: rtl/present3_core.sv
module present3_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pt_load,
  input  logic [3:0]  pt_nib1,
  input  logic [3:0]  pt_nib2,
  input  logic [3:0]  pt_nib3,
  input  logic        key_load,
  input  logic [3:0]  key_nib,
  input  logic        start,
  input  logic [7:0]  mask_in,
  output logic        done,
  output logic [63:0] ct1,
  output logic [63:0] ct2,
  output logic [63:0] ct3
);
  localparam int LAST_PH  = 16;
  localparam int LAST_RND = 31;

  logic [63:0] st1, st2, st3;
  logic [79:0] key;
  logic [3:0]  h1, h2, h3;
  logic [4:0]  ph, rnd;
  logic        busy;

  function automatic logic [3:0] sbox(input logic [3:0] x);
    case (x)
      4'h0: sbox = 4'hC; 4'h1: sbox = 4'h5; 4'h2: sbox = 4'h6; 4'h3: sbox = 4'hB;
      4'h4: sbox = 4'h9; 4'h5: sbox = 4'h0; 4'h6: sbox = 4'hA; 4'h7: sbox = 4'hD;
      4'h8: sbox = 4'h3; 4'h9: sbox = 4'hE; 4'hA: sbox = 4'hF; 4'hB: sbox = 4'h8;
      4'hC: sbox = 4'h4; 4'hD: sbox = 4'h7; 4'hE: sbox = 4'h1; default: sbox = 4'h2;
    endcase
  endfunction

  function automatic logic qt(input logic xp, input logic yp, input logic xq, input logic yq);
    qt = (xp & yp) ^ (xp & yq) ^ (xq & yp);
  endfunction

  // first quadratic stage; p supplies linear terms, q the cross terms
  function automatic logic [3:0] g_part(input logic [3:0] p, input logic [3:0] q, input logic one);
    logic [3:0] o;
    o[0] = one ^ p[0] ^ qt(p[3], p[2], q[3], q[2]) ^ qt(p[3], p[1], q[3], q[1])
               ^ qt(p[2], p[1], q[2], q[1]);
    o[1] = one ^ p[3] ^ p[1] ^ qt(p[2], p[0], q[2], q[0]) ^ qt(p[1], p[0], q[1], q[0])
               ^ (p[2] & p[1]) ^ (q[2] & q[1]);
    o[2] = one ^ p[2] ^ p[1];
    o[3] = p[2] ^ p[1] ^ p[0];
    return o;
  endfunction

  function automatic logic [3:0] f_part(input logic [3:0] p, input logic [3:0] q);
    logic [3:0] o;
    o[0] = p[1] ^ qt(p[2], p[0], q[2], q[0]);
    o[1] = p[1] ^ p[2] ^ qt(p[3], p[0], q[3], q[0]);
    o[2] = p[3] ^ qt(p[1], p[0], q[1], q[0]);
    o[3] = p[0] ^ p[1] ^ p[2] ^ qt(p[3], p[0], q[3], q[0]);
    return o;
  endfunction

  function automatic logic [63:0] perm64(input logic [63:0] v);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < 63; i++) o[(i * 16) % 63] = v[i];
    o[63] = v[63];
    return o;
  endfunction

  function automatic logic [79:0] kupd(input logic [79:0] k, input logic [4:0] r);
    logic [79:0] t;
    t = {k[18:0], k[79:19]};
    t[79:76] = sbox(t[79:76]);
    t[19:15] = t[19:15] ^ r;
    return t;
  endfunction

  logic [3:0] kn, x1, x2, x3, y1, y2, y3;
  assign kn = key[79 - 4 * ph[3:0] -: 4];
  assign x1 = st1[63:60] ^ kn;
  assign x2 = st2[63:60];
  assign x3 = st3[63:60];
  assign y1 = f_part(h2, h3);
  assign y2 = f_part(h3, h1);
  assign y3 = f_part(h1, h2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1 <= '0; h2 <= '0; h3 <= '0;
    end else begin
      h1 <= g_part(x2, x3, 1'b1) ^ mask_in[3:0];
      h2 <= g_part(x3, x1, 1'b0) ^ mask_in[7:4];
      h3 <= g_part(x1, x2, 1'b0) ^ mask_in[3:0] ^ mask_in[7:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1 <= '0; st2 <= '0; st3 <= '0; key <= '0;
      ph <= '0; rnd <= '0; busy <= 1'b0; done <= 1'b0;
    end else if (!busy) begin
      if (pt_load) begin
        st1 <= {st1[59:0], pt_nib1};
        st2 <= {st2[59:0], pt_nib2};
        st3 <= {st3[59:0], pt_nib3};
      end
      if (key_load) key <= {key[75:0], key_nib};
      if (pt_load || key_load) done <= 1'b0;
      if (start) begin
        busy <= 1'b1; done <= 1'b0; ph <= '0; rnd <= 5'd1;
      end
    end else if (ph == 5'(LAST_PH)) begin
      st1 <= perm64({st1[59:0], y1});
      st2 <= perm64({st2[59:0], y2});
      st3 <= perm64({st3[59:0], y3});
      key <= kupd(key, rnd);
      ph  <= '0;
      if (rnd == 5'(LAST_RND)) begin
        busy <= 1'b0; done <= 1'b1;
      end else rnd <= rnd + 5'd1;
    end else begin
      st1 <= {st1[59:0], y1};
      st2 <= {st2[59:0], y2};
      st3 <= {st3[59:0], y3};
      ph  <= ph + 5'd1;
    end
  end

  assign ct1 = st1 ^ key[79:16];
  assign ct2 = st2;
  assign ct3 = st3;
endmodule

// File: rtl/present3_core_chk.sv
module present3_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        pt_load,
  input logic        key_load,
  input logic        busy,
  input logic        done,
  input logic [4:0]  ph,
  input logic [4:0]  rnd,
  input logic [63:0] ct1,
  input logic [63:0] ct2,
  input logic [63:0] ct3
);
  logic [9:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy) lat <= lat + 10'd1;
  end

  // R4
  latency_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat == 10'd527);

  // R4
  no_done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph <= 5'd16 && rnd >= 5'd1 && rnd <= 5'd31));

  // R7
  load_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rnd < 5'd31) |=> busy);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !pt_load && !key_load) |=>
      ($stable(ct1) && $stable(ct2) && $stable(ct3) && done));
endmodule

bind present3_core present3_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pt_load(pt_load), .key_load(key_load),
  .busy(busy), .done(done), .ph(ph), .rnd(rnd), .ct1(ct1), .ct2(ct2), .ct3(ct3)
);

// File: tb/sim_present3_core.sv
module sim_present3_core;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pt_load = 1'b0, key_load = 1'b0, start = 1'b0;
  logic [3:0] pt_nib1 = '0, pt_nib2 = '0, pt_nib3 = '0, key_nib = '0;
  logic [7:0] mask_in = '0;
  logic done;
  logic [63:0] ct1, ct2, ct3;
  int total = 0, bad = 0;

  present3_core u0 (.*);

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [3:0] ref_sb(input logic [3:0] x);
    logic [63:0] t;
    t = 64'hC56B90AD3EF84712;
    return t[63 - 4 * x -: 4];
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [79:0] k);
    logic [63:0] s, p;
    logic [79:0] kk;
    s = pt; kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[79:16];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = ref_sb(s[4*n +: 4]);
      p = '0;
      for (int b = 0; b < 64; b++) p[(b == 63) ? 63 : (b * 16) % 63] = s[b];
      s = p;
      kk = (kk << 61) | (kk >> 19);
      kk[79:76] = ref_sb(kk[79:76]);
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_all(input logic [63:0] s1, s2, s3, input logic [79:0] k);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pt_load = (i < 16);
      if (i < 16) begin
        pt_nib1 = s1[63 - 4*i -: 4]; pt_nib2 = s2[63 - 4*i -: 4]; pt_nib3 = s3[63 - 4*i -: 4];
      end
      key_load = 1'b1; key_nib = k[79 - 4*i -: 4];
    end
    @(negedge clk);
    pt_load = 1'b0; key_load = 1'b0;
  endtask

  task automatic run(input string req, input logic [63:0] pt, input logic [79:0] k,
                     input logic [63:0] m2, m3, input bit zmask, input bit disturb,
                     output logic [63:0] res);
    load_all(pt ^ m2 ^ m3, m2, m3, k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 527; c++) begin
      mask_in = zmask ? 8'h00 : 8'($urandom);
      if (disturb && c == 100) begin
        pt_load = 1'b1; key_load = 1'b1; start = 1'b1;
        pt_nib1 = 4'($urandom); pt_nib2 = 4'($urandom); pt_nib3 = 4'($urandom);
        key_nib = 4'($urandom);
      end else begin
        pt_load = 1'b0; key_load = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      if (c == 526) chk("R4 done early", 64'(done), 64'd0);
      if (c == 527) chk("R4 done at 527", 64'(done), 64'd1);
    end
    res = ct1 ^ ct2 ^ ct3;
    chk(req, res, ref_enc(pt, k));
    repeat (6) begin
      mask_in = 8'($urandom);
      @(negedge clk);
    end
    chk("R8 hold", ct1 ^ ct2 ^ ct3, res);
    chk("R8 done held", 64'(done), 64'd1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r, ra, rb, pt;
    logic [79:0] k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 shares after reset", ct1 ^ ct2 ^ ct3, 64'd0);

    run("R9 zero vector", '0, '0, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, r);
    chk("R9 zero known answer", r, 64'h5579C1387B228445);
    run("R9 ones vector", '1, '1, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, r);
    chk("R9 ones known answer", r, 64'h3333DCD3213210D2);

    pt = {$urandom, $urandom}; k = {16'($urandom), $urandom, $urandom};
    run("R5 zero masks", pt, k, '0, '0, 1, 0, r);

    run("R6 masks A", pt, k, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, ra);
    run("R6 masks B", pt, k, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, rb);
    chk("R6 mask independence", ra, rb);

    run("R2 share split", 64'h0123456789ABCDEF, 80'h00112233445566778899,
        64'hFFFF0000FFFF0000, 64'h5A5A5A5A5A5A5A5A, 0, 0, r);

    pt = {$urandom, $urandom}; k = {16'($urandom), $urandom, $urandom};
    run("R7 disturbed run", pt, k, {$urandom, $urandom}, {$urandom, $urandom}, 0, 1, r);

    for (int t = 0; t < 5; t++) begin
      pt = {$urandom, $urandom}; k = {16'($urandom), $urandom, $urandom};
      run("R3 random", pt, k, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule